// File: doc/BRIEF.md
# Operand-Matched Computation Reuse Table

This block sits beside the issue logic of a processor pipeline. It lets an instruction skip execution when the same operation has already been computed with the same operand values. The earlier computation may have come from any static instruction, not only the one now asking. The block keeps three tables:

- **Pointer table.** It is indexed by the low bits of the instruction address and tagged with the upper bits. Each slot holds a pointer plus a generation stamp, not a result.
- **Computation table.** It is shared by all instruction addresses. Each entry holds an opcode, both operand values, a result field and a generation counter. For a load, the result field holds the effective address.
- **Memory table.** It is direct-mapped and holds an address and data pair for each slot, so a load can reuse its value.

The block has three ports:

- **Update port.** Executed instructions write here. A fully associative search finds an existing computation with the same opcode and operands, so no duplicate entry is ever made. If there is no match, a new entry is allocated: the lowest free slot, or else a round-robin victim. The pointer table slot for the instruction address is then pointed at that entry.
- **Lookup port.** A lookup steps through a state machine:
  - `ST_IDLE` → `ST_PTR`: the request is accepted when `lk_valid` is high and `lk_ready` is high.
  - `ST_PTR` → `ST_ENTRY`: the pointer table is read.
  - `ST_ENTRY` → `ST_TEST`: the computation entry is read and its generation is checked.
  - `ST_TEST` → `ST_MEM`: taken when the reuse test passes and the opcode is the load opcode.
  - `ST_TEST` → `ST_DONE`: taken in every other case.
  - `ST_MEM` → `ST_DONE`: the memory table is read.
  - `ST_DONE` → `ST_IDLE`: a one-cycle response is given.
- **Store port.** A store clears any memory table entry that holds the stored address.

Top module: `rrt_reuse_buffer`

## Requirements
- R1: After reset, `lk_ready` is 1 and `rsp_valid` is 0, and every lookup misses.
- R2: A lookup hits when all of the following hold, and it then returns the stored result:
  - the pointer table slot for its PC holds a matching tag;
  - the pointed entry's generation matches the stamp in the slot;
  - the entry's opcode and both operands equal the request's.
- R2 (cont.): A lookup that differs only in opcode misses. On a miss, `rsp_result` is 0.
- R3: An update whose opcode and operands equal an existing entry reuses that entry, so a second PC shares it. At most one entry ever matches a given opcode and operand pair.
- R4: An update with new operands allocates a new entry and repoints its PC. A lookup with the old operands at that PC then misses. Other PCs that point at the old entry still hit.
- R5: Opcode 4'hF is a load. On a passing reuse test, a load returns the memory table data whose address equals the entry's result field. A load update writes `up_ld_data` at address `up_res`.
- R6: A store whose address matches a memory table entry clears that entry. A later load lookup to that address then misses. A store to an absent address changes nothing. If a store and a load update hit the same address in the same cycle, the clear wins.
- R7: When no entry is free, allocation evicts entries in round-robin order starting at entry 0. PCs still pointing at an evicted entry miss, because the generation stamp no longer matches.
- R8: `lk_ready` is 1 only in `ST_IDLE`. `rsp_valid` is a single-cycle pulse. It comes 4 clock edges after acceptance for non-load opcodes and 5 for loads.
- R9: A lookup whose PC maps to the same slot as a stored PC but carries a different upper tag misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_pc | input | PC_W | Lookup instruction address |
| lk_op | input | OP_W | Lookup opcode |
| lk_a | input | D_W | Lookup first operand |
| lk_b | input | D_W | Lookup second operand |
| rsp_valid | output | 1 | Lookup response pulse |
| rsp_hit | output | 1 | Reuse succeeded |
| rsp_result | output | D_W | Reused value, 0 on miss |
| up_valid | input | 1 | Executed-instruction update |
| up_pc | input | PC_W | Update instruction address |
| up_op | input | OP_W | Update opcode |
| up_a | input | D_W | Update first operand |
| up_b | input | D_W | Update second operand |
| up_res | input | D_W | Result, or effective address for loads |
| up_ld_data | input | D_W | Loaded value, used when the opcode is the load opcode |
| st_valid | input | 1 | Store invalidate |
| st_addr | input | D_W | Store address |

## Verification
The assertions check, on every cycle:
- that no two computation entries ever match the same opcode and operand pair;
- that the victim pointer advances by one on each eviction;
- that a store leaves no matching memory entry behind;
- that the response is a single pulse;
- that the memory state is entered only for loads.

Only the bench scenarios can show sharing across PCs, repointing on operand change, generation-based miss after eviction, tag aliasing, and exact response latency. These all depend on sequences of updates followed by lookups.

// File: rtl/rrt_pkg.sv
package rrt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PTR,
        ST_ENTRY,
        ST_TEST,
        ST_MEM,
        ST_DONE
    } lk_state_t;
endpackage

// File: rtl/rrt_pc_table.sv
module rrt_pc_table #(
    parameter int PC_W  = 16,
    parameter int PI_W  = 4,
    parameter int CI_W  = 3,
    parameter int GEN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PC_W-1:0]  wr_pc,
    input  logic [CI_W-1:0]  wr_idx,
    input  logic [GEN_W-1:0] wr_gen,
    input  logic [PC_W-1:0]  rd_pc,
    output logic             rd_hit,
    output logic [CI_W-1:0]  rd_idx,
    output logic [GEN_W-1:0] rd_gen
);
    localparam int SLOTS = 1 << PI_W;
    localparam int TAG_W = PC_W - PI_W;

    logic [SLOTS-1:0] vld;
    logic [TAG_W-1:0] tag_q [SLOTS];
    logic [CI_W-1:0]  idx_q [SLOTS];
    logic [GEN_W-1:0] gen_q [SLOTS];

    logic [PI_W-1:0] w_slot, r_slot;
    assign w_slot = wr_pc[PI_W-1:0];
    assign r_slot = rd_pc[PI_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
            for (int i = 0; i < SLOTS; i++) begin
                tag_q[i] <= '0;
                idx_q[i] <= '0;
                gen_q[i] <= '0;
            end
        end else if (wr_en) begin
            vld[w_slot]   <= 1'b1;
            tag_q[w_slot] <= wr_pc[PC_W-1:PI_W];
            idx_q[w_slot] <= wr_idx;
            gen_q[w_slot] <= wr_gen;
        end
    end

    assign rd_hit = vld[r_slot] && (tag_q[r_slot] == rd_pc[PC_W-1:PI_W]);
    assign rd_idx = idx_q[r_slot];
    assign rd_gen = gen_q[r_slot];
endmodule

// File: rtl/rrt_calc_table.sv
module rrt_calc_table #(
    parameter int N     = 8,
    parameter int OP_W  = 4,
    parameter int D_W   = 16,
    parameter int GEN_W = 3,
    parameter int I_W   = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_valid,
    input  logic [OP_W-1:0]  up_op,
    input  logic [D_W-1:0]   up_a,
    input  logic [D_W-1:0]   up_b,
    input  logic [D_W-1:0]   up_res,
    output logic [I_W-1:0]   up_idx,
    output logic [GEN_W-1:0] up_gen,
    input  logic [I_W-1:0]   rd_idx,
    output logic             rd_valid,
    output logic [OP_W-1:0]  rd_op,
    output logic [D_W-1:0]   rd_a,
    output logic [D_W-1:0]   rd_b,
    output logic [D_W-1:0]   rd_res,
    output logic [GEN_W-1:0] rd_gen
);
    logic [N-1:0]     vld;
    logic [OP_W-1:0]  op_q  [N];
    logic [D_W-1:0]   a_q   [N];
    logic [D_W-1:0]   b_q   [N];
    logic [D_W-1:0]   res_q [N];
    logic [GEN_W-1:0] gen_q [N];
    logic [I_W-1:0]   rr;

    logic [N-1:0] hit_vec, free_vec;
    logic [I_W-1:0] hit_idx, free_idx, alloc_idx;
    logic any_hit, any_free;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g]  = vld[g] && (op_q[g] == up_op) &&
                             (a_q[g] == up_a) && (b_q[g] == up_b);
        assign free_vec[g] = !vld[g];
    end

    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i])  hit_idx  = I_W'(i);
            if (free_vec[i]) free_idx = I_W'(i);
        end
    end

    assign any_hit   = |hit_vec;
    assign any_free  = |free_vec;
    assign alloc_idx = any_free ? free_idx : rr;
    assign up_idx    = any_hit ? hit_idx : alloc_idx;
    assign up_gen    = any_hit ? gen_q[hit_idx] : gen_q[alloc_idx] + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
            rr  <= '0;
            for (int i = 0; i < N; i++) begin
                op_q[i]  <= '0;
                a_q[i]   <= '0;
                b_q[i]   <= '0;
                res_q[i] <= '0;
                gen_q[i] <= '0;
            end
        end else if (up_valid && !any_hit) begin
            vld[alloc_idx]   <= 1'b1;
            op_q[alloc_idx]  <= up_op;
            a_q[alloc_idx]   <= up_a;
            b_q[alloc_idx]   <= up_b;
            res_q[alloc_idx] <= up_res;
            gen_q[alloc_idx] <= gen_q[alloc_idx] + 1'b1;
            if (!any_free) begin
                rr <= (rr == I_W'(N - 1)) ? '0 : rr + 1'b1;
            end
        end
    end

    assign rd_valid = vld[rd_idx];
    assign rd_op    = op_q[rd_idx];
    assign rd_a     = a_q[rd_idx];
    assign rd_b     = b_q[rd_idx];
    assign rd_res   = res_q[rd_idx];
    assign rd_gen   = gen_q[rd_idx];

    assert_unique_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    assert_victim_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !any_hit && !any_free) |=>
        (rr == (($past(rr) == I_W'(N - 1)) ? '0 : $past(rr) + 1'b1)));
endmodule

// File: rtl/rrt_mem_table.sv
module rrt_mem_table #(
    parameter int N   = 8,
    parameter int D_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [D_W-1:0] wr_addr,
    input  logic [D_W-1:0] wr_data,
    input  logic           st_valid,
    input  logic [D_W-1:0] st_addr,
    input  logic [D_W-1:0] rd_addr,
    output logic           rd_hit,
    output logic [D_W-1:0] rd_data
);
    localparam int MI_W = $clog2(N);

    logic [N-1:0]   vld;
    logic [D_W-1:0] addr_q [N];
    logic [D_W-1:0] data_q [N];

    logic [MI_W-1:0] w_slot, s_slot, r_slot;
    assign w_slot = wr_addr[MI_W-1:0];
    assign s_slot = st_addr[MI_W-1:0];
    assign r_slot = rd_addr[MI_W-1:0];

    logic s_match;
    assign s_match = st_valid &&
        ((vld[s_slot] && addr_q[s_slot] == st_addr) || (wr_en && wr_addr == st_addr));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
            for (int i = 0; i < N; i++) begin
                addr_q[i] <= '0;
                data_q[i] <= '0;
            end
        end else begin
            if (wr_en) begin
                vld[w_slot]    <= 1'b1;
                addr_q[w_slot] <= wr_addr;
                data_q[w_slot] <= wr_data;
            end
            if (s_match) begin
                vld[s_slot] <= 1'b0;
            end
        end
    end

    assign rd_hit  = vld[r_slot] && (addr_q[r_slot] == rd_addr);
    assign rd_data = data_q[r_slot];

    logic           chk_q;
    logic [D_W-1:0] chk_addr_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_q      <= 1'b0;
            chk_addr_q <= '0;
        end else begin
            chk_q      <= st_valid;
            chk_addr_q <= st_addr;
        end
    end

    assert_store_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        chk_q |-> !(vld[chk_addr_q[MI_W-1:0]] && addr_q[chk_addr_q[MI_W-1:0]] == chk_addr_q));
endmodule

// File: rtl/rrt_reuse_buffer.sv
module rrt_reuse_buffer
    import rrt_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int PI_W   = 4,
    parameter int CALC_N = 8,
    parameter int MEM_N  = 8,
    parameter int OP_W   = 4,
    parameter int D_W    = 16,
    parameter int GEN_W  = 3,
    parameter int LD_OP  = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lk_valid,
    output logic            lk_ready,
    input  logic [PC_W-1:0] lk_pc,
    input  logic [OP_W-1:0] lk_op,
    input  logic [D_W-1:0]  lk_a,
    input  logic [D_W-1:0]  lk_b,
    output logic            rsp_valid,
    output logic            rsp_hit,
    output logic [D_W-1:0]  rsp_result,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic [OP_W-1:0] up_op,
    input  logic [D_W-1:0]  up_a,
    input  logic [D_W-1:0]  up_b,
    input  logic [D_W-1:0]  up_res,
    input  logic [D_W-1:0]  up_ld_data,
    input  logic            st_valid,
    input  logic [D_W-1:0]  st_addr
);
    localparam int CI_W = $clog2(CALC_N);
    localparam logic [OP_W-1:0] LOAD = OP_W'(LD_OP);

    lk_state_t state, nxt;

    logic [PC_W-1:0]  q_pc;
    logic [OP_W-1:0]  q_op;
    logic [D_W-1:0]   q_a, q_b;
    logic             p_hit;
    logic [CI_W-1:0]  p_idx;
    logic [GEN_W-1:0] p_gen;
    logic             e_ok;
    logic [OP_W-1:0]  e_op;
    logic [D_W-1:0]   e_a, e_b, e_res;
    logic [D_W-1:0]   m_addr;
    logic             hit_q;
    logic [D_W-1:0]   res_q;
    logic             pass;

    logic             pt_hit;
    logic [CI_W-1:0]  pt_idx;
    logic [GEN_W-1:0] pt_gen;
    logic [CI_W-1:0]  ct_up_idx;
    logic [GEN_W-1:0] ct_up_gen;
    logic             ct_valid;
    logic [OP_W-1:0]  ct_op;
    logic [D_W-1:0]   ct_a, ct_b, ct_res;
    logic [GEN_W-1:0] ct_gen;
    logic             mt_hit;
    logic [D_W-1:0]   mt_data;

    rrt_pc_table #(.PC_W(PC_W), .PI_W(PI_W), .CI_W(CI_W), .GEN_W(GEN_W)) u_pc (
        .clk(clk), .rst_n(rst_n),
        .wr_en(up_valid), .wr_pc(up_pc), .wr_idx(ct_up_idx), .wr_gen(ct_up_gen),
        .rd_pc(q_pc), .rd_hit(pt_hit), .rd_idx(pt_idx), .rd_gen(pt_gen)
    );

    rrt_calc_table #(.N(CALC_N), .OP_W(OP_W), .D_W(D_W), .GEN_W(GEN_W), .I_W(CI_W)) u_calc (
        .clk(clk), .rst_n(rst_n),
        .up_valid(up_valid), .up_op(up_op), .up_a(up_a), .up_b(up_b), .up_res(up_res),
        .up_idx(ct_up_idx), .up_gen(ct_up_gen),
        .rd_idx(p_idx), .rd_valid(ct_valid), .rd_op(ct_op), .rd_a(ct_a), .rd_b(ct_b),
        .rd_res(ct_res), .rd_gen(ct_gen)
    );

    rrt_mem_table #(.N(MEM_N), .D_W(D_W)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .wr_en(up_valid && up_op == LOAD), .wr_addr(up_res), .wr_data(up_ld_data),
        .st_valid(st_valid), .st_addr(st_addr),
        .rd_addr(m_addr), .rd_hit(mt_hit), .rd_data(mt_data)
    );

    assign pass = e_ok && (e_op == q_op) && (e_a == q_a) && (e_b == q_b);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (lk_valid) nxt = ST_PTR;
            ST_PTR:   nxt = ST_ENTRY;
            ST_ENTRY: nxt = ST_TEST;
            ST_TEST:  nxt = (pass && q_op == LOAD) ? ST_MEM : ST_DONE;
            ST_MEM:   nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_pc <= '0; q_op <= '0; q_a <= '0; q_b <= '0;
            p_hit <= 1'b0; p_idx <= '0; p_gen <= '0;
            e_ok <= 1'b0; e_op <= '0; e_a <= '0; e_b <= '0; e_res <= '0;
            m_addr <= '0; hit_q <= 1'b0; res_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (lk_valid) begin
                    q_pc <= lk_pc; q_op <= lk_op; q_a <= lk_a; q_b <= lk_b;
                end
                ST_PTR: begin
                    p_hit <= pt_hit; p_idx <= pt_idx; p_gen <= pt_gen;
                end
                ST_ENTRY: begin
                    e_ok  <= p_hit && ct_valid && (ct_gen == p_gen);
                    e_op  <= ct_op; e_a <= ct_a; e_b <= ct_b; e_res <= ct_res;
                end
                ST_TEST: begin
                    m_addr <= e_res;
                    hit_q  <= pass;
                    res_q  <= pass ? e_res : '0;
                end
                ST_MEM: begin
                    hit_q <= mt_hit;
                    res_q <= mt_hit ? mt_data : '0;
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        lk_ready   = (state == ST_IDLE);
        rsp_valid  = (state == ST_DONE);
        rsp_hit    = rsp_valid && hit_q;
        rsp_result = rsp_valid ? res_q : '0;
    end

    assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready) |=> (!lk_ready && !rsp_valid));

    assert_mem_only_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MEM) |-> (q_op == LOAD));
endmodule

// File: tb/rrt_reuse_buffer_bench.sv
module rrt_reuse_buffer_bench;
    localparam logic [3:0] OP_ADD = 4'h1;
    localparam logic [3:0] OP_DIV = 4'h3;
    localparam logic [3:0] OP_LD  = 4'hF;
    localparam logic [1:0] K_UP = 2'd0, K_LK = 2'd1, K_ST = 2'd2;

    typedef struct packed {
        logic [1:0]  kind;
        logic [15:0] pc;
        logic [3:0]  op;
        logic [15:0] a;
        logic [15:0] b;
        logic [15:0] res;
        logic [15:0] ld;
        logic        ehit;
        logic [15:0] eres;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{K_LK, 16'h0011, OP_DIV, 16'd8,     16'd2, 16'd0,     16'h0000, 1'b0, 16'd0},     // R1 empty
        '{K_UP, 16'h0011, OP_DIV, 16'd8,     16'd2, 16'd4,     16'h0000, 1'b0, 16'd0},
        '{K_LK, 16'h0011, OP_DIV, 16'd8,     16'd2, 16'd0,     16'h0000, 1'b1, 16'd4},     // R2
        '{K_UP, 16'h0012, OP_DIV, 16'd8,     16'd2, 16'd4,     16'h0000, 1'b0, 16'd0},     // R3 share
        '{K_LK, 16'h0012, OP_DIV, 16'd8,     16'd2, 16'd0,     16'h0000, 1'b1, 16'd4},     // R3
        '{K_LK, 16'h0011, OP_DIV, 16'd9,     16'd3, 16'd0,     16'h0000, 1'b0, 16'd0},     // R4 new operands
        '{K_UP, 16'h0011, OP_DIV, 16'd9,     16'd3, 16'd3,     16'h0000, 1'b0, 16'd0},
        '{K_LK, 16'h0011, OP_DIV, 16'd9,     16'd3, 16'd0,     16'h0000, 1'b1, 16'd3},     // R4
        '{K_LK, 16'h0012, OP_DIV, 16'd8,     16'd2, 16'd0,     16'h0000, 1'b1, 16'd4},     // R4 other PC kept
        '{K_LK, 16'h0011, OP_DIV, 16'd8,     16'd2, 16'd0,     16'h0000, 1'b0, 16'd0},     // R4 repointed
        '{K_LK, 16'h0021, OP_DIV, 16'd9,     16'd3, 16'd0,     16'h0000, 1'b0, 16'd0},     // R9 alias
        '{K_UP, 16'h0013, OP_LD,  16'h0100,  16'd4, 16'h0104,  16'hBEEF, 1'b0, 16'd0},
        '{K_LK, 16'h0013, OP_LD,  16'h0100,  16'd4, 16'd0,     16'h0000, 1'b1, 16'hBEEF},  // R5
        '{K_ST, 16'h0000, 4'h0,   16'h0104,  16'd0, 16'd0,     16'h0000, 1'b0, 16'd0},     // R6 store
        '{K_LK, 16'h0013, OP_LD,  16'h0100,  16'd4, 16'd0,     16'h0000, 1'b0, 16'd0},     // R6
        '{K_UP, 16'h0013, OP_LD,  16'h0100,  16'd4, 16'h0104,  16'hCAFE, 1'b0, 16'd0},
        '{K_LK, 16'h0013, OP_LD,  16'h0100,  16'd4, 16'd0,     16'h0000, 1'b1, 16'hCAFE},  // R5
        '{K_ST, 16'h0000, 4'h0,   16'h0222,  16'd0, 16'd0,     16'h0000, 1'b0, 16'd0},     // R6 absent
        '{K_LK, 16'h0013, OP_LD,  16'h0100,  16'd4, 16'd0,     16'h0000, 1'b1, 16'hCAFE},  // R6
        '{K_LK, 16'h0013, OP_ADD, 16'h0100,  16'd4, 16'd0,     16'h0000, 1'b0, 16'd0}      // R2 opcode differs
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic lk_valid = 1'b0, lk_ready, rsp_valid, rsp_hit;
    logic [15:0] lk_pc = '0, lk_a = '0, lk_b = '0, rsp_result;
    logic [3:0]  lk_op = '0, up_op = '0;
    logic up_valid = 1'b0, st_valid = 1'b0;
    logic [15:0] up_pc = '0, up_a = '0, up_b = '0, up_res = '0, up_ld_data = '0, st_addr = '0;

    int tests = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rrt_reuse_buffer u_rrt_reuse_buffer (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_pc(lk_pc), .lk_op(lk_op),
        .lk_a(lk_a), .lk_b(lk_b),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_result(rsp_result),
        .up_valid(up_valid), .up_pc(up_pc), .up_op(up_op), .up_a(up_a), .up_b(up_b),
        .up_res(up_res), .up_ld_data(up_ld_data),
        .st_valid(st_valid), .st_addr(st_addr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_update(input logic [15:0] pc, input logic [3:0] op,
                             input logic [15:0] a, input logic [15:0] b,
                             input logic [15:0] res, input logic [15:0] ld);
        up_valid = 1'b1; up_pc = pc; up_op = op; up_a = a; up_b = b;
        up_res = res; up_ld_data = ld;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic do_store(input logic [15:0] addr);
        st_valid = 1'b1; st_addr = addr;
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic do_lookup(input string req, input logic [15:0] pc, input logic [3:0] op,
                             input logic [15:0] a, input logic [15:0] b,
                             input logic ehit, input logic [15:0] eres);
        int lat;
        lk_valid = 1'b1; lk_pc = pc; lk_op = op; lk_a = a; lk_b = b;
        @(negedge clk);
        lk_valid = 1'b0;
        lat = 1;
        check({req, " R8 busy"}, {31'd0, lk_ready}, 32'd0);
        while (!rsp_valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check({req, " R8 latency"}, lat, (op == OP_LD && ehit) || (op == OP_LD && pc == 16'h0013) ? 32'd5 : 32'd4);
        check({req, " hit"}, {31'd0, rsp_hit}, {31'd0, ehit});
        check({req, " result"}, {16'd0, rsp_result}, {16'd0, eres});
        @(negedge clk);
        check({req, " R8 pulse"}, {31'd0, rsp_valid}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ready", {31'd0, lk_ready}, 32'd1);
        check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            case (v.kind)
                K_UP: do_update(v.pc, v.op, v.a, v.b, v.res, v.ld);
                K_ST: do_store(v.a);
                default: do_lookup($sformatf("vec%0d", i), v.pc, v.op, v.a, v.b, v.ehit, v.eres);
            endcase
        end

        // R7 fill entries 3..7, then evict entry 0 (div 8/2) and entry 1 (div 9/3)
        for (int i = 1; i <= 5; i++) begin
            do_update(16'h0013 + 16'(i), OP_ADD, 16'(i), 16'd0, 16'(i), 16'd0);
        end
        do_update(16'h0019, OP_ADD, 16'd100, 16'd100, 16'd200, 16'd0);
        do_lookup("R7 evicted", 16'h0012, OP_DIV, 16'd8, 16'd2, 1'b0, 16'd0);
        do_lookup("R7 new", 16'h0019, OP_ADD, 16'd100, 16'd100, 1'b1, 16'd200);
        do_lookup("R7 survivor", 16'h0011, OP_DIV, 16'd9, 16'd3, 1'b1, 16'd3);
        do_update(16'h001A, OP_ADD, 16'd7, 16'd7, 16'd14, 16'd0);
        do_lookup("R7 second victim", 16'h0011, OP_DIV, 16'd9, 16'd3, 1'b0, 16'd0);
        do_lookup("R7 load kept", 16'h0013, OP_LD, 16'h0100, 16'd4, 1'b1, 16'hCAFE);

        // R6 store and load update to same address in one cycle: clear wins
        st_valid = 1'b1; st_addr = 16'h0104;
        do_update(16'h0013, OP_LD, 16'h0100, 16'd4, 16'h0104, 16'h1234);
        st_valid = 1'b0;
        do_lookup("R6 same cycle", 16'h0013, OP_LD, 16'h0100, 16'd4, 1'b0, 16'd0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule